// File: doc/BRIEF.md
# Move-to-Front Dictionary Word Decompressor

This block turns a stream of dictionary codewords back into the original sequence of 32-bit words. Each codeword arrives whole on a valid/ready input. It is packed right-aligned in a fixed-width field, and a bit count says how many of the low bits are meaningful. For each accepted codeword the block presents exactly one 32-bit word on a valid/ready output. A codeword is either a literal word, or a reference to a dictionary slot with a byte mask. Bytes the mask does not select arrive inline as literals.

The block keeps a copy of the encoder's dictionary. It applies the same move-to-front update after every codeword, so slot numbers keep meaning the same thing on both sides. The slot field is as narrow as the current number of filled slots allows. A codeword that names an empty slot returns a zero word flagged as an error and leaves the dictionary as it was.

Back-pressure: a codeword is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in that cycle, so one codeword per cycle flows while `out_ready` stays high. While `out_valid` is high and `out_ready` is low, `out_word` and `out_err` do not change and no new codeword is taken.

Top module: `mtf_decomp`

## Requirements
- R1: After reset the dictionary holds no entries, `out_valid` is low and `in_ready` is high.
- R2: A codeword of L bits sits in `in_code[L-1:0]`, with its first bit at position L-1 and the rest following toward bit 0. `in_len` gives L. Bits of `in_code` at or above L are ignored.
- R3: A first bit of 1 marks a literal. The next 32 bits, most significant first, are the output word.
- R4: A first bit of 0 marks a hit. It is followed, most significant bit first, by three parts. The first is a slot number of W bits, where W = 0 when the dictionary holds N ≤ 1 entries and W = ceil(log2 N) otherwise. The second is a 4-bit mask whose first bit stands for byte 3 (bits 31:24) and whose last bit stands for byte 0. The third is one literal byte for every mask bit that is 0, in order from the most significant such byte down. A mask bit of 1 takes that byte from the slot.
- R5: A hit with mask 1111 at slot L moves slots 0..L-1 down by one and writes the word to slot 0. The entry count does not change.
- R6: A literal, or a hit with any other mask, moves every slot down by one and drops the last slot. It writes the word to slot 0 and raises the entry count by one unless the count already equals DEPTH.
- R7: A hit whose slot number is not below the entry count (any hit while the dictionary is empty) produces `out_word` = 0 with `out_err` = 1, and leaves the dictionary and count unchanged.
- R8: Each accepted codeword yields exactly one output word. While `out_valid` is high and `out_ready` is low, `out_word` and `out_err` hold and `in_ready` is low.
- R9: With `out_ready` held high, a codeword is accepted on every cycle. A lookup uses the dictionary as already updated by the codeword accepted on the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Codeword present |
| in_ready | output | 1 | Block can take a codeword this cycle |
| in_code | input | CW_W = 1+LOC_W+36 | Right-aligned codeword bits |
| in_len | input | LEN_W | Number of meaningful codeword bits |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the output word |
| out_word | output | 32 | Rebuilt word (0 on error) |
| out_err | output | 1 | Codeword named an empty slot |

## Verification
Two events can land on the same edge. The consumer drains a word while the next codeword is accepted, and that new codeword often reads slot 0, which the previous codeword wrote on the edge before. A long opening stretch keeps `in_valid` and `out_ready` high so these collisions happen every cycle. Later stretches toggle both handshakes at random and include a mostly stalled period. A behavioural queue-based dictionary in the bench predicts `in_ready`, `out_valid`, `out_word` and `out_err` for every cycle. Every mismatch is reported against the requirement that the codeword kind exercises.

// File: rtl/mtf_pkg.sv
package mtf_pkg;
  localparam int WORD_W  = 32;
  localparam int NBYTES  = WORD_W / 8;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [NBYTES-1:0] bmask_t;

  // slot-number width for a dictionary holding n entries
  function automatic int slot_width(input int n);
    if (n <= 1) return 0;
    return $clog2(n);
  endfunction
endpackage

// File: rtl/mtf_cw_parse.sv
module mtf_cw_parse
  import mtf_pkg::*;
#(
  parameter int LOC_W = 4,
  parameter int CNT_W = 5,
  parameter int CW_W  = 41,
  parameter int LEN_W = 6
) (
  input  logic [CW_W-1:0]  code,
  input  logic [LEN_W-1:0] len,
  input  logic [CNT_W-1:0] count,
  output logic             is_lit,
  output logic [LOC_W-1:0] loc,
  output bmask_t           mask,
  output word_t            lit,
  output logic             loc_bad
);
  localparam logic [LEN_W-1:0] CW_LEN = LEN_W'(CW_W);

  logic [CW_W-1:0]  norm, after_flag, after_loc, after_mask;
  logic [LOC_W-1:0] loc_raw;
  int               lw;

  always_comb begin
    // left-align so the first codeword bit sits at the top
    if (len >= CW_LEN) norm = code;
    else               norm = code << (CW_LEN - len);
    lw         = slot_width(int'(count));
    is_lit     = norm[CW_W-1];
    after_flag = norm << 1;
    loc_raw    = after_flag[CW_W-1 -: LOC_W];
    loc        = (lw == 0) ? '0 : (loc_raw >> (LOC_W - lw));
    after_loc  = after_flag << lw;
    mask       = after_loc[CW_W-1 -: NBYTES];
    after_mask = after_loc << NBYTES;
    lit        = is_lit ? after_flag[CW_W-1 -: WORD_W] : after_mask[CW_W-1 -: WORD_W];
    loc_bad    = !is_lit && (int'(loc) >= int'(count));
  end
endmodule

// File: rtl/mtf_byte_merge.sv
module mtf_byte_merge
  import mtf_pkg::*;
(
  input  bmask_t mask,
  input  word_t  dict_word,
  input  word_t  lit,
  output word_t  merged
);
  int ptr;

  always_comb begin
    ptr    = 0;
    merged = '0;
    for (int b = NBYTES - 1; b >= 0; b--) begin
      if (mask[b]) begin
        merged[8*b +: 8] = dict_word[8*b +: 8];
      end else begin
        merged[8*b +: 8] = lit[(WORD_W - 1 - 8*ptr) -: 8];
        ptr = ptr + 1;
      end
    end
  end
endmodule

// File: rtl/mtf_dict_store.sv
module mtf_dict_store
  import mtf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LOC_W = 4,
  parameter int CNT_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd,
  input  logic                    keep_tail,
  input  logic [LOC_W-1:0]        loc,
  input  word_t                   din,
  output logic [DEPTH-1:0][WORD_W-1:0] entries,
  output logic [CNT_W-1:0]        count
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  word_t slot_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   slot_q[i] <= '0;
        else if (upd) slot_q[i] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q[i] <= '0;
        else if (upd && (!keep_tail || int'(loc) >= i)) slot_q[i] <= slot_q[i-1];
      end
    end
    assign entries[i] = slot_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               count <= '0;
    else if (upd && !keep_tail && count != FULL) count <= count + 1'b1;
  end
endmodule

// File: rtl/mtf_decomp.sv
module mtf_decomp
  import mtf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LOC_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int CW_W  = 1 + LOC_W + NBYTES + WORD_W,
  localparam int LEN_W = $clog2(CW_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CW_W-1:0]  in_code,
  input  logic [LEN_W-1:0] in_len,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_word,
  output logic             out_err
);
  logic                         is_lit, loc_bad, full_hit, accept, upd;
  logic [LOC_W-1:0]             loc;
  bmask_t                       mask;
  word_t                        lit, dict_word, merged, word_next;
  logic [DEPTH-1:0][WORD_W-1:0] entries;
  logic [CNT_W-1:0]             dict_count;

  mtf_cw_parse #(.LOC_W(LOC_W), .CNT_W(CNT_W), .CW_W(CW_W), .LEN_W(LEN_W)) u_parse (
    .code(in_code), .len(in_len), .count(dict_count),
    .is_lit(is_lit), .loc(loc), .mask(mask), .lit(lit), .loc_bad(loc_bad)
  );

  always_comb begin
    dict_word = '0;
    for (int i = 0; i < DEPTH; i++)
      if (int'(loc) == i) dict_word = entries[i];
  end

  mtf_byte_merge u_merge (
    .mask(mask), .dict_word(dict_word), .lit(lit), .merged(merged)
  );

  assign word_next = is_lit ? lit : merged;
  assign full_hit  = !is_lit && (mask == '1);
  assign in_ready  = !out_valid || out_ready;
  assign accept    = in_valid && in_ready;
  assign upd       = accept && !loc_bad;

  mtf_dict_store #(.DEPTH(DEPTH), .LOC_W(LOC_W), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .upd(upd), .keep_tail(full_hit), .loc(loc),
    .din(word_next), .entries(entries), .count(dict_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_err   <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_word  <= loc_bad ? '0 : word_next;
      out_err   <= loc_bad;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mtf_decomp_chk.sv
module mtf_decomp_chk #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [31:0]      out_word,
  input logic             out_err,
  input logic [CNT_W-1:0] count,
  input logic             full_hit,
  input logic             loc_bad
);
  logic take;
  assign take = in_valid && in_ready;

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_err)));

  assert_one_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  assert_bad_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && loc_bad) |=> ($stable(count) && out_err && out_word == 32'd0));

  assert_full_hit_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !loc_bad && full_hit) |=> $stable(count));

  assert_grow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !loc_bad && !full_hit && int'(count) < DEPTH) |=> (int'(count) == int'($past(count)) + 1));

  assert_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);
endmodule

bind mtf_decomp mtf_decomp_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word), .out_err(out_err),
  .count(dict_count), .full_hit(full_hit), .loc_bad(loc_bad)
);

// File: tb/mtf_decomp_bench.sv
module mtf_decomp_bench;
  localparam int DEPTH = 16;
  localparam int LOC_W = $clog2(DEPTH);
  localparam int CW_W  = 1 + LOC_W + 4 + 32;
  localparam int LEN_W = $clog2(CW_W + 1);
  localparam int NCYC  = 4000;
  localparam int P1    = 400;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n, in_valid, in_ready, out_valid, out_ready, out_err;
  logic [CW_W-1:0]  in_code;
  logic [LEN_W-1:0] in_len;
  logic [31:0]      out_word;

  mtf_decomp #(.DEPTH(DEPTH)) u_mtf_decomp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .in_len(in_len), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word), .out_err(out_err)
  );

  int vectors = 0, miscompares = 0;

  // reference state
  logic [31:0] dq[$];
  bit          m_valid = 0, m_err = 0;
  logic [31:0] m_word = '0;
  string       m_tag = "R3";

  // pending codeword
  bit          have_cw = 0, cw_err;
  int          cw_kind, cw_loc;
  logic [31:0] cw_word;
  string       cw_tag;
  logic [63:0] acc;
  int          acc_len;

  function automatic int swidth(input int n);
    if (n <= 1) return 0;
    return $clog2(n);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic push_bits(input logic [63:0] bits, input int n);
    if (n > 0) begin
      acc = (acc << n) | (bits & ((64'd1 << n) - 64'd1));
      acc_len += n;
    end
  endtask

  task automatic build_cw();
    int n, w, r;
    bit can_bad;
    logic [3:0] m;
    logic [63:0] g;
    n = dq.size();
    w = swidth(n);
    can_bad = (n == 0) || (n > 1 && (1 << w) > n);
    acc = '0; acc_len = 0;
    r = $urandom % 100;
    if (n == 0) cw_kind = (r < 60) ? 0 : 3;
    else if (r < 25) cw_kind = 0;
    else if (r < 60) cw_kind = 1;
    else if (r < 90) cw_kind = 2;
    else cw_kind = can_bad ? 3 : 0;
    cw_err = 0;
    case (cw_kind)
      0: begin
        cw_word = $urandom; cw_tag = "R3/R2";
        push_bits(1, 1); push_bits(64'(cw_word), 32);
      end
      1: begin
        cw_loc = $urandom % n; cw_word = dq[cw_loc]; cw_tag = "R5/R4";
        push_bits(0, 1); push_bits(64'(cw_loc), w); push_bits(64'hF, 4);
      end
      2: begin
        cw_loc = $urandom % n; m = 4'($urandom % 15); cw_tag = "R4/R6";
        for (int b = 0; b < 4; b++)
          cw_word[8*b +: 8] = m[b] ? dq[cw_loc][8*b +: 8] : 8'($urandom);
        push_bits(0, 1); push_bits(64'(cw_loc), w); push_bits(64'(m), 4);
        for (int b = 3; b >= 0; b--)
          if (!m[b]) push_bits(64'(cw_word[8*b +: 8]), 8);
      end
      default: begin
        cw_loc = n + int'($urandom % ((1 << w) - n));
        m = 4'($urandom); cw_word = 32'd0; cw_err = 1; cw_tag = "R7";
        push_bits(0, 1); push_bits(64'(cw_loc), w); push_bits(64'(m), 4);
        for (int b = 3; b >= 0; b--)
          if (!m[b]) push_bits(64'($urandom % 256), 8);
      end
    endcase
    g = {$urandom, $urandom};
    if (acc_len < 64) g = g << acc_len; else g = '0;
    in_code = CW_W'(acc | g);   // R2: junk above the codeword
    in_len  = LEN_W'(acc_len);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL R8 watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    int p1_accepts = 0;
    bit accept;
    rst_n = 0; in_valid = 0; out_ready = 0; in_code = '0; in_len = '0;
    repeat (3) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R1", "out_valid in reset", 32'(out_valid), 32'd0);
      check(in_ready == 1'b1, "R1", "in_ready in reset", 32'(in_ready), 32'd1);
    end
    rst_n = 1;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(negedge clk);
      check(out_valid == m_valid, "R8/R9", "out_valid", 32'(out_valid), 32'(m_valid));
      check(in_ready == (!m_valid || out_ready), "R8/R9", "in_ready",
            32'(in_ready), 32'(!m_valid || out_ready));
      if (m_valid) begin
        check(out_word == m_word, m_tag, "out_word", out_word, m_word);
        check(out_err == m_err, m_tag, "out_err", 32'(out_err), 32'(m_err));
      end
      // drive the next cycle
      if (cyc < P1)                          out_ready = 1'b1;
      else if (cyc >= 2000 && cyc < 2400)    out_ready = ($urandom % 4) == 0;
      else                                   out_ready = ($urandom % 4) != 0;
      if (!have_cw && (cyc < P1 || ($urandom % 4) != 0)) begin
        build_cw();
        have_cw = 1;
      end
      in_valid = have_cw;
      accept = have_cw && (!m_valid || out_ready);
      if (accept) begin
        if (cyc < P1) p1_accepts++;
        m_valid = 1; m_tag = cw_tag; m_err = cw_err;
        m_word  = cw_err ? 32'd0 : cw_word;
        if (!cw_err) begin
          if (cw_kind == 1) dq.delete(cw_loc);
          dq.push_front(cw_word);
          if (dq.size() > DEPTH) void'(dq.pop_back());
        end
        have_cw = 0;
      end else if (m_valid && out_ready) begin
        m_valid = 0;
      end
    end
    // R9: one acceptance per cycle during the unstalled opening stretch
    check(p1_accepts == P1, "R9", "accepts in free-flow stretch", 32'(p1_accepts), 32'(P1));
    finish_run();
  end
endmodule